// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers up to 32 external interrupt lines into two processor-facing request outputs. Every source has its own sensitivity (level or edge), its own active polarity, and its own routing to either a normal or a critical (machine-check class) request. Capture results are kept in a status register that software clears by writing ones. An enable register gates which status bits may reach an output, and a masked-status register shows what is pending after gating.

Sources are numbered from the most significant bit downward: source n lives in bit (31 − n) of every per-source register. Sources 17, 18 and 19 are reserved and never assert. A combinational priority encoder reports the lowest-numbered pending source, so source 0 has the highest priority. Raw inputs pass through a two-flop synchronizer before capture. Software reaches the registers over a simple synchronous bus: writes take effect at the clock edge, and read data is a combinational decode of the word address.

Top module: `irqc_top`

## Requirements
- R1: After reset, status, enable, polarity, trigger and the vector configuration word read 0, the routing register reads all ones, and both request outputs and the valid flag are 0. Source n occupies bit 31 − n of every per-source register.
- R2: Word addresses are 0 status, 1 enable, 2 routing, 3 polarity, 4 trigger, 5 masked status (read-only), 6 vector configuration. A write happens at the clock edge where bus_sel and bus_wr are both 1. bus_rdata is a combinational decode of bus_addr.
- R3: Writing a 1 to a status bit clears it at that edge. A 0 leaves that bit unchanged.
- R4: A level source (trigger bit 0) has a status bit that follows its active input. An input change appears in status after three clock edges. After a clear, the bit sets again on the next edge while the input stays active.
- R5: An edge source (trigger bit 1) sets its status bit on an active edge, and the bit stays set until software clears it. An edge detected in the same cycle as a clear wins, so the bit stays 1.
- R6: Polarity bit 1 means active-high or rising edge. Polarity bit 0 means active-low or falling edge. An edge of the other direction does not set status.
- R7: Status, enable and masked-status bits of sources 17 to 19 (bits 14, 13, 12) always read 0. Writes to these bits are ignored.
- R8: Masked status equals status AND enable. irq_norm is the OR of masked bits whose routing bit is 1. irq_crit is the OR of masked bits whose routing bit is 0.
- R9: top_vld is 1 when any masked bit is set. top_idx is then the lowest-numbered pending source. top_idx is 0 when top_vld is 0.
- R10: Clearing an enable bit masks the source but keeps its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_in | input | 32 | Raw interrupt lines; bit 31 − n is source n |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |
| top_vld | output | 1 | Some masked source is pending |
| top_idx | output | 5 | Lowest-numbered pending source |

## Verification
The bench builds the block with its default parameters. These are two synchronizer stages and a reserved mask covering sources 17 to 19. With these values the three-edge input latency is fixed, so the bench can sample in an exact cycle. It also means that patterns touching only the reserved bits must leave the valid flag low. A vector table of active-high level patterns covers the priority encoder across the whole source range: both ends, the bits next to the reserved group, and the reserved bits on their own. Directed sequences then cover clearing, edge stickiness, a clear that collides with an edge, falling-edge polarity, masking and critical routing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned SRC_N = 32;
    localparam int unsigned IDX_W = $clog2(SRC_N);

    typedef logic [SRC_N-1:0] srcvec_t;

    typedef enum logic [2:0] {
        A_STAT  = 3'd0,
        A_ENAB  = 3'd1,
        A_ROUTE = 3'd2,
        A_POL   = 3'd3,
        A_TRIG  = 3'd4,
        A_MSTAT = 3'd5,
        A_VCFG  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        srcvec_t     enab;
        srcvec_t     route;
        srcvec_t     pol;
        srcvec_t     trig;
        logic [31:0] vcfg;
    } cfg_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irqc_pkg::srcvec_t din,
    output irqc_pkg::srcvec_t dout
);
    import irqc_pkg::*;

    srcvec_t [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    // Reset to all ones: lines idle high under the active-low reset polarity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter irqc_pkg::srcvec_t RSV_MASK = 32'h0000_7000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irqc_pkg::srcvec_t sync_in,
    input  irqc_pkg::srcvec_t pol,
    input  irqc_pkg::srcvec_t trig,
    input  irqc_pkg::srcvec_t clr,
    output irqc_pkg::srcvec_t status
);
    import irqc_pkg::*;

    typedef struct packed {
        srcvec_t stat;
        srcvec_t act_prev;
    } cap_t;

    cap_t    cap_d, cap_q;
    srcvec_t act, edge_hit, lvl_next, edg_next;

    always_comb begin
        act      = ~(sync_in ^ pol);
        edge_hit = act & ~cap_q.act_prev;
        lvl_next = act & ~clr;
        edg_next = edge_hit | (cap_q.stat & ~clr);
        cap_d.act_prev = act;
        cap_d.stat     = ((trig & edg_next) | (~trig & lvl_next)) & ~RSV_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign status = cap_q.stat;

    // R7: reserved sources never hold status
    p_rsv_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.stat & RSV_MASK) == '0);

    // R5: an edge source that was set and not cleared remains set
    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cap_q.stat) & $past(trig) & ~$past(clr)) & ~cap_q.stat) == '0));

    // R4: a level source is never set after a cycle with its input inactive
    p_level_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_q.stat & ~$past(trig) & ~$past(act)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio (
    input  logic                           clk,
    input  logic                           rst_n,
    input  irqc_pkg::srcvec_t              masked,
    output logic                           vld,
    output logic [irqc_pkg::IDX_W-1:0]     idx
);
    import irqc_pkg::*;

    always_comb begin
        idx = '0;
        for (int n = SRC_N - 1; n >= 0; n--) begin
            if (masked[SRC_N-1-n]) idx = IDX_W'(n);
        end
        vld = |masked;
    end

    // R9: the reported source is pending and none of higher priority is
    p_idx_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> masked[IDX_W'(SRC_N-1) - idx]);
    p_idx_highest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((masked >> (SRC_N - 32'(idx))) == '0));
    p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |-> (idx == '0 && masked == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter irqc_pkg::srcvec_t RSV_MASK    = 32'h0000_7000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] irq_in,
    output logic        irq_norm,
    output logic        irq_crit,
    output logic        top_vld,
    output logic [4:0]  top_idx
);
    import irqc_pkg::*;

    cfg_t    cfg_d, cfg_q;
    srcvec_t sync_v, status, masked, clr;
    logic    wr_en;

    assign wr_en = bus_sel && bus_wr;
    assign clr   = (wr_en && bus_addr == A_STAT) ? bus_wdata : '0;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(sync_v));

    irqc_capture #(.RSV_MASK(RSV_MASK)) u_cap (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_v), .pol(cfg_q.pol),
        .trig(cfg_q.trig), .clr(clr), .status(status));

    assign masked = status & cfg_q.enab;

    irqc_prio u_prio (
        .clk(clk), .rst_n(rst_n), .masked(masked), .vld(top_vld), .idx(top_idx));

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (bus_addr)
                A_ENAB:  cfg_d.enab  = bus_wdata & ~RSV_MASK;
                A_ROUTE: cfg_d.route = bus_wdata;
                A_POL:   cfg_d.pol   = bus_wdata;
                A_TRIG:  cfg_d.trig  = bus_wdata;
                A_VCFG:  cfg_d.vcfg  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{enab: '0, route: '1, pol: '0, trig: '0, vcfg: '0};
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (bus_addr)
            A_STAT:  bus_rdata = status;
            A_ENAB:  bus_rdata = cfg_q.enab;
            A_ROUTE: bus_rdata = cfg_q.route;
            A_POL:   bus_rdata = cfg_q.pol;
            A_TRIG:  bus_rdata = cfg_q.trig;
            A_MSTAT: bus_rdata = masked;
            A_VCFG:  bus_rdata = cfg_q.vcfg;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_norm = |(masked & cfg_q.route);
    assign irq_crit = |(masked & ~cfg_q.route);

    // R8: with nothing enabled, no request is raised
    p_no_req_when_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.enab == '0) |-> (!irq_norm && !irq_crit));

    // R8: any request implies a pending masked source
    p_req_has_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm || irq_crit) |-> top_vld);

    // R7: reserved enable bits stay clear
    p_rsv_enab_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.enab & RSV_MASK) == '0);

    // R10: writing the enable register never clears an edge status bit
    p_mask_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_ENAB) |=> (((($past(status) & $past(cfg_q.trig)) & ~status)) == '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_STAT = 3'd0, A_ENAB = 3'd1, A_ROUTE = 3'd2,
                           A_POL = 3'd3, A_TRIG = 3'd4, A_MSTAT = 3'd5, A_VCFG = 3'd6;
    localparam logic [31:0] RSV = 32'h0000_7000;

    typedef struct packed {
        logic [31:0] pat;
        logic [4:0]  idx;
        logic        vld;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{pat: 32'h8000_0000, idx: 5'd0,  vld: 1'b1},
        '{pat: 32'h0000_0001, idx: 5'd31, vld: 1'b1},
        '{pat: 32'h0000_7000, idx: 5'd0,  vld: 1'b0},
        '{pat: 32'h0000_7800, idx: 5'd20, vld: 1'b1},
        '{pat: 32'h0001_7000, idx: 5'd15, vld: 1'b1},
        '{pat: 32'h0000_0000, idx: 5'd0,  vld: 1'b0},
        '{pat: 32'h00F0_0F00, idx: 5'd8,  vld: 1'b1},
        '{pat: 32'hFFFF_FFFF, idx: 5'd0,  vld: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] irq_in = '1;
    logic        irq_norm, irq_crit, top_vld;
    logic [4:0]  top_idx;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_norm(irq_norm), .irq_crit(irq_crit),
        .top_vld(top_vld), .top_idx(top_idx));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(4);

        // R1: reset values
        rd_chk("R1 status", A_STAT, 32'h0);
        rd_chk("R1 enable", A_ENAB, 32'h0);
        rd_chk("R1 route", A_ROUTE, 32'hFFFF_FFFF);
        rd_chk("R1 polarity", A_POL, 32'h0);
        rd_chk("R1 trigger", A_TRIG, 32'h0);
        rd_chk("R1 masked", A_MSTAT, 32'h0);
        rd_chk("R1 vcfg", A_VCFG, 32'h0);
        chk("R1 outputs", {29'd0, irq_norm, irq_crit, top_vld}, 32'h0);

        // R7 / R2: reserved enable bits ignore writes; plain word reads back
        wr(A_ENAB, 32'hFFFF_FFFF);
        rd_chk("R7 enable reserved", A_ENAB, 32'hFFFF_8FFF);
        wr(A_VCFG, 32'h1234_5678);
        rd_chk("R2 vcfg readback", A_VCFG, 32'h1234_5678);
        wr(A_MSTAT, 32'hFFFF_FFFF);
        rd_chk("R2 masked read-only", A_MSTAT, 32'h0);

        // Table: active-high level sources, priority and masking
        irq_in = '0;
        wr(A_POL, 32'hFFFF_FFFF);
        step(3);
        for (int i = 0; i < NVEC; i++) begin
            irq_in = TBL[i].pat;
            step(3);
            chk("R9 valid", {31'd0, top_vld}, {31'd0, TBL[i].vld});
            chk("R9 index", {27'd0, top_idx}, {27'd0, TBL[i].idx});
            rd_chk("R8 masked", A_MSTAT, TBL[i].pat & ~RSV);
            rd_chk("R7 status reserved", A_STAT, TBL[i].pat & ~RSV);
            chk("R8 normal out", {31'd0, irq_norm}, {31'd0, TBL[i].vld});
            chk("R8 critical out", {31'd0, irq_crit}, 32'h0);
        end

        // R3 / R4: clear of an active level source re-sets on the next edge
        irq_in = 32'h8000_0000;
        step(3);
        rd_chk("R4 level set", A_STAT, 32'h8000_0000);
        wr(A_STAT, 32'h8000_0000);
        rd_chk("R3 cleared", A_STAT, 32'h0);
        step(1);
        rd_chk("R4 level re-set", A_STAT, 32'h8000_0000);
        wr(A_STAT, 32'h0);
        rd_chk("R3 zero write keeps", A_STAT, 32'h8000_0000);

        // R10: masking keeps status
        wr(A_ENAB, 32'h0);
        rd_chk("R10 status kept", A_STAT, 32'h8000_0000);
        rd_chk("R10 masked zero", A_MSTAT, 32'h0);
        chk("R10 no request", {30'd0, irq_norm, irq_crit}, 32'h0);
        wr(A_ENAB, 32'hFFFF_FFFF);

        // R8: critical routing
        wr(A_ROUTE, 32'h7FFF_FFFF);
        chk("R8 crit routed", {30'd0, irq_norm, irq_crit}, 32'h1);
        wr(A_ROUTE, 32'hFFFF_FFFF);
        chk("R8 norm routed", {30'd0, irq_norm, irq_crit}, 32'h2);

        // R5: source 31 edge, rising
        irq_in = '0;
        step(3);
        wr(A_TRIG, 32'h0000_0001);
        rd_chk("R5 idle edge", A_STAT, 32'h0);
        irq_in = 32'h1;
        step(3);
        rd_chk("R5 edge set", A_STAT, 32'h1);
        chk("R9 index src31", {27'd0, top_idx}, 32'd31);
        irq_in = '0;
        step(3);
        rd_chk("R5 sticky", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        rd_chk("R3 edge cleared", A_STAT, 32'h0);
        irq_in = 32'h1;
        step(3);
        irq_in = '0;
        step(3);
        irq_in = 32'h1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(A_STAT, 32'h1);
        rd_chk("R5 edge beats clear", A_STAT, 32'h1);

        // R6: falling-edge polarity
        wr(A_POL, 32'hFFFF_FFFE);
        wr(A_STAT, 32'h1);
        rd_chk("R6 cleared before falling", A_STAT, 32'h0);
        irq_in = '0;
        step(3);
        rd_chk("R6 falling sets", A_STAT, 32'h1);
        wr(A_STAT, 32'h1);
        irq_in = 32'h1;
        step(3);
        rd_chk("R6 rising ignored", A_STAT, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule